// File: doc/BRIEF.md
# Microcode ALU with Carry Variants

This block is the arithmetic and logic unit of a small microcode engine. It takes two 16-bit operands, a 5-bit operation code and two 4-bit field controls. It returns a 16-bit result and a carry-out, both combinationally in the same cycle. Add and subtract each come in four forms. A form may read the stored carry flag, may write it, may do both, or may do neither. The remaining operations are bitwise logic, logical and arithmetic shifts, rotates, a bit-clear, a 32-bit funnel extract and a bit-field insert.

The carry flag is the only state in the block. It loads on a clock edge only when `in_valid` is high and the operation is a carry-writing form. Operations are presented with `in_valid`, and the block accepts every one of them. There is no back-pressure and no ready signal, because the datapath finishes its work within the cycle. When `in_valid` is low, the result and carry-out are still computed, but the flag is left alone. Register files, operand fetch, instruction decoding and immediate handling belong to the surrounding engine.

Top module: `ucode_alu`

## Requirements
- R1: An active-low `rst_n` clears `carry_flag` to 0 asynchronously. The flag stays 0 until a carry-writing operation is accepted.
- R2: Opcode 0 (add) returns A+B mod 2^16. Opcode 4 (subtract) returns A-B mod 2^16. For these, `carry_out` is the carry out of bit 15 of A+B, or of A+~B+1 for subtract, so a subtract carry of 1 means no borrow.
- R3: Opcodes 1 (add, write carry) and 5 (subtract, write carry) give the result and `carry_out` of R2. On the next clock edge with `in_valid` high, `carry_flag` takes that `carry_out`.
- R4: Opcode 2 returns A+B+flag, and opcode 6 returns A-B-(1-flag), where flag is `carry_flag`. Their carry-out is computed as A+B+flag and A+~B+flag. Opcodes 3 and 7 compute the same results and also load `carry_flag` as in R3.
- R5: `carry_flag` holds its value in any cycle where `in_valid` is low or the opcode is not 1, 3, 5 or 7.
- R6: Opcode 8 is OR, 9 is AND, 10 is XOR and 16 is bit-clear (A AND NOT B). All four give `carry_out` = 0.
- R7: Opcode 11 is logical right shift of A, 12 is left shift of A, and 13 is arithmetic right shift of A. The shift amount is B[3:0]. `carry_out` is 0.
- R8: Opcode 14 rotates A left and opcode 15 rotates A right, both by B[3:0]. `carry_out` is 0.
- R9: Opcode 17 (extract) returns ({B,A} >> S) masked to its low W+1 bits, where S = `fld_shift` and W = `fld_width`. `carry_out` is 0.
- R10: Opcode 18 (insert) forms the field mask ((2^(W+1))-1) << S, truncated to 16 bits. It returns (A << S) inside the mask and B outside it. `carry_out` is 0.
- R11: Opcodes 19 to 31 return result 0 and `carry_out` 0, and never change `carry_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation is accepted this cycle; qualifies the flag write |
| op | input | 5 | Operation code |
| opnd_a | input | 16 | First operand |
| opnd_b | input | 16 | Second operand, also the shift amount source |
| fld_width | input | 4 | Field width minus one for extract and insert |
| fld_shift | input | 4 | Field position for extract and insert |
| result | output | 16 | Combinational result |
| carry_out | output | 1 | Combinational carry of the current operation |
| carry_flag | output | 1 | Stored carry flag |

## Verification
Two things can land in the same cycle: a with-carry operation reading the stored flag, and the same operation writing a new flag at the closing edge. This happens with opcodes 3 and 7. The random stream issues back-to-back chains of these opcodes, mixed with cycles where `in_valid` is low, so the bench sees many cycles in which the flag just read is about to be replaced. Each cycle is judged against a bench model of the flag: the result must reflect the old flag, and `carry_flag` seen in the following cycle must equal the carry predicted for the previous operation.

// File: rtl/ucode_alu_pkg.sv
package ucode_alu_pkg;

  typedef enum logic [4:0] {
    OP_ADD     = 5'd0,
    OP_ADD_W   = 5'd1,
    OP_ADDC    = 5'd2,
    OP_ADDC_W  = 5'd3,
    OP_SUB     = 5'd4,
    OP_SUB_W   = 5'd5,
    OP_SUBC    = 5'd6,
    OP_SUBC_W  = 5'd7,
    OP_OR      = 5'd8,
    OP_AND     = 5'd9,
    OP_XOR     = 5'd10,
    OP_SHR     = 5'd11,
    OP_SHL     = 5'd12,
    OP_SAR     = 5'd13,
    OP_ROL     = 5'd14,
    OP_ROR     = 5'd15,
    OP_CLR     = 5'd16,
    OP_XTRACT  = 5'd17,
    OP_INSERT  = 5'd18
  } alu_op_e;

  // Arithmetic codes occupy 0..7: bit0 writes the flag, bit1 reads it, bit2 selects subtract
  function automatic logic op_is_arith(input logic [4:0] code);
    return code[4:3] == 2'b00;
  endfunction

  function automatic logic op_writes_flag(input logic [4:0] code);
    return op_is_arith(code) && code[0];
  endfunction

  function automatic logic op_reads_flag(input logic [4:0] code);
    return code[1];
  endfunction

  function automatic logic op_is_sub(input logic [4:0] code);
    return code[2];
  endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int DW = 16
) (
  input  logic          is_sub,
  input  logic          use_flag,
  input  logic          flag,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] sum,
  output logic          cout
);
  logic [DW-1:0] b_eff;
  logic          cin;
  logic [DW:0]   wide;

  always_comb begin
    b_eff = is_sub ? ~b : b;
    // without the flag, subtract injects 1 to complete the two's complement
    cin   = use_flag ? flag : is_sub;
    wide  = {1'b0, a} + {1'b0, b_eff} + {{DW{1'b0}}, cin};
    sum   = wide[DW-1:0];
    cout  = wide[DW];
  end
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int DW = 16
) (
  input  logic [1:0]    sel,
  input  logic          clr,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] y
);
  always_comb begin
    if (clr) begin
      y = a & ~b;
    end else begin
      unique case (sel)
        2'd0:    y = a | b;
        2'd1:    y = a & b;
        2'd2:    y = a ^ b;
        default: y = '0;
      endcase
    end
  end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
  parameter int DW = 16,
  parameter int SW = $clog2(DW)
) (
  input  logic [2:0]    sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [SW-1:0] fld_w,
  input  logic [SW-1:0] fld_s,
  output logic [DW-1:0] y
);
  localparam int CW = 2 * DW;

  logic [SW-1:0] amt;
  logic [SW:0]   w_plus1;
  logic [DW-1:0] low_mask;
  logic [DW-1:0] fld_mask;
  logic [CW-1:0] rot_l;
  logic [CW-1:0] rot_r;
  logic [CW-1:0] funnel;
  logic [DW-1:0] res_shr, res_shl, res_sar, res_rol, res_ror, res_xtr, res_ins;

  always_comb begin
    amt      = b[SW-1:0];
    w_plus1  = {1'b0, fld_w} + (SW+1)'(1);
    low_mask = ~({DW{1'b1}} << w_plus1);
    fld_mask = low_mask << fld_s;
    res_shr  = a >> amt;
    res_shl  = a << amt;
    res_sar  = DW'($signed(a) >>> amt);
    rot_l    = {a, a} << amt;
    rot_r    = {a, a} >> amt;
    res_rol  = rot_l[CW-1:DW];
    res_ror  = rot_r[DW-1:0];
    funnel   = {b, a} >> fld_s;
    res_xtr  = funnel[DW-1:0] & low_mask;
    res_ins  = (b & ~fld_mask) | ((a << fld_s) & fld_mask);
  end

  always_comb begin
    unique case (sel)
      3'd0:    y = res_shr;
      3'd1:    y = res_shl;
      3'd2:    y = res_sar;
      3'd3:    y = res_rol;
      3'd4:    y = res_ror;
      3'd5:    y = res_xtr;
      3'd6:    y = res_ins;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/ucode_alu.sv
module ucode_alu
  import ucode_alu_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int FLD_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [4:0]        op,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  input  logic [FLD_W-1:0]  fld_width,
  input  logic [FLD_W-1:0]  fld_shift,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              carry_flag
);
  logic [DATA_W-1:0] arith_y, logic_y, shift_y;
  logic              arith_co;
  logic [1:0]        logic_sel;
  logic              logic_clr;
  logic [2:0]        shift_sel;
  logic              pick_logic, pick_shift;

  alu_addsub #(.DW(DATA_W)) u_addsub (
    .is_sub   (op_is_sub(op)),
    .use_flag (op_reads_flag(op)),
    .flag     (carry_flag),
    .a        (opnd_a),
    .b        (opnd_b),
    .sum      (arith_y),
    .cout     (arith_co)
  );

  always_comb begin
    logic_sel  = 2'd3;
    logic_clr  = 1'b0;
    shift_sel  = 3'd7;
    pick_logic = 1'b0;
    pick_shift = 1'b0;
    case (op)
      OP_OR:     begin logic_sel = 2'd0; pick_logic = 1'b1; end
      OP_AND:    begin logic_sel = 2'd1; pick_logic = 1'b1; end
      OP_XOR:    begin logic_sel = 2'd2; pick_logic = 1'b1; end
      OP_CLR:    begin logic_clr = 1'b1; pick_logic = 1'b1; end
      OP_SHR:    begin shift_sel = 3'd0; pick_shift = 1'b1; end
      OP_SHL:    begin shift_sel = 3'd1; pick_shift = 1'b1; end
      OP_SAR:    begin shift_sel = 3'd2; pick_shift = 1'b1; end
      OP_ROL:    begin shift_sel = 3'd3; pick_shift = 1'b1; end
      OP_ROR:    begin shift_sel = 3'd4; pick_shift = 1'b1; end
      OP_XTRACT: begin shift_sel = 3'd5; pick_shift = 1'b1; end
      OP_INSERT: begin shift_sel = 3'd6; pick_shift = 1'b1; end
      default:   ;
    endcase
  end

  alu_bitwise #(.DW(DATA_W)) u_bitwise (
    .sel (logic_sel),
    .clr (logic_clr),
    .a   (opnd_a),
    .b   (opnd_b),
    .y   (logic_y)
  );

  alu_shifter #(.DW(DATA_W), .SW(FLD_W)) u_shifter (
    .sel   (shift_sel),
    .a     (opnd_a),
    .b     (opnd_b),
    .fld_w (fld_width),
    .fld_s (fld_shift),
    .y     (shift_y)
  );

  always_comb begin
    if (op_is_arith(op))  result = arith_y;
    else if (pick_logic)  result = logic_y;
    else if (pick_shift)  result = shift_y;
    else                  result = '0;
    carry_out = op_is_arith(op) ? arith_co : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                carry_flag <= 1'b0;
    else if (in_valid && op_writes_flag(op))   carry_flag <= carry_out;
  end

  AST_FLAG_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (op == OP_ADD_W || op == OP_ADDC_W || op == OP_SUB_W || op == OP_SUBC_W))
      |=> carry_flag == $past(carry_out)); // R3

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid || !(op == OP_ADD_W || op == OP_ADDC_W || op == OP_SUB_W || op == OP_SUBC_W))
      |=> $stable(carry_flag)); // R5

  AST_NO_CARRY_LOGIC: assert property (@(posedge clk) disable iff (!rst_n)
    (op >= 5'd8) |-> !carry_out); // R6

  AST_EXTRACT_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_XTRACT && fld_width != {FLD_W{1'b1}})
      |-> (result >> (32'(fld_width) + 1)) == '0); // R9

  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (op > 5'd18) |-> (result == '0)); // R11

endmodule

// File: tb/sim_ucode_alu.sv
module sim_ucode_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  op = '0;
  logic [15:0] opnd_a = '0, opnd_b = '0;
  logic [3:0]  fld_width = '0, fld_shift = '0;
  logic [15:0] result;
  logic        carry_out, carry_flag;

  int errors = 0;
  int checks = 0;
  logic mflag = 1'b0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  ucode_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .fld_width(fld_width), .fld_shift(fld_shift),
    .result(result), .carry_out(carry_out), .carry_flag(carry_flag)
  );

  function automatic string req_of(input logic [4:0] c);
    if (c == 0 || c == 4) return "R2";
    if (c == 1 || c == 5) return "R3";
    if (c == 2 || c == 3 || c == 6 || c == 7) return "R4";
    if (c == 8 || c == 9 || c == 10 || c == 16) return "R6";
    if (c >= 11 && c <= 13) return "R7";
    if (c == 14 || c == 15) return "R8";
    if (c == 17) return "R9";
    if (c == 18) return "R10";
    return "R11";
  endfunction

  function automatic logic [16:0] model(input logic [4:0] c, input logic [15:0] a,
      input logic [15:0] b, input logic [3:0] w, input logic [3:0] s, input logic f);
    logic [31:0] t, msk, cat;
    logic [3:0]  n;
    n = b[3:0];
    t = 0;
    case (c)
      0, 1: t = a + b;
      2, 3: t = a + b + f;
      4, 5: t = a + (~b & 16'hFFFF) + 1;
      6, 7: t = a + (~b & 16'hFFFF) + f;
      8:  t = a | b;
      9:  t = a & b;
      10: t = a ^ b;
      11: t = a >> n;
      12: t = (a << n) & 16'hFFFF;
      13: t = {16'h0, 16'($signed(a) >>> n)};
      14: t = ((32'(a) << n) | (32'(a) >> (16 - n))) & 16'hFFFF;
      15: t = ((32'(a) >> n) | (32'(a) << (16 - n))) & 16'hFFFF;
      16: t = a & ~b;
      17: begin cat = {b, a}; t = (cat >> s) & ((32'd1 << (w + 1)) - 1); end
      18: begin
        msk = (((32'd1 << (w + 1)) - 1) << s) & 32'hFFFF;
        t = (b & ~msk) | ((32'(a) << s) & msk);
      end
      default: t = 0;
    endcase
    if (c > 7) t[16] = 1'b0;
    return {t[16], t[15:0]};
  endfunction

  task automatic check(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [4:0] c, input logic [15:0] a, input logic [15:0] b,
      input logic [3:0] w, input logic [3:0] s, input logic v);
    logic [16:0] e;
    @(negedge clk);
    op = c; opnd_a = a; opnd_b = b; fld_width = w; fld_shift = s; in_valid = v;
    #1;
    e = model(c, a, b, w, s, mflag);
    check(req_of(c), "result", result, e[15:0]);
    check(req_of(c), "carry_out", carry_out, e[16]);
    check((v && c <= 7 && c[0]) ? "R3" : "R5", "carry_flag", carry_flag, mflag);
    @(posedge clk);
    if (v && c <= 7 && c[0]) mflag = e[16];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    #1 check("R1", "carry_flag in reset", carry_flag, 0);
    rst_n = 1'b1;
    // directed corners
    do_op(5'd1, 16'hFFFF, 16'h0001, 0, 0, 1);   // R3 wraps to 0, carry 1
    do_op(5'd0, 16'h1234, 16'h0001, 0, 0, 1);   // R2 plain add keeps flag
    do_op(5'd2, 16'h0010, 16'h0020, 0, 0, 1);   // R4 uses flag=1
    do_op(5'd5, 16'h0003, 16'h0005, 0, 0, 1);   // R3 borrow: carry 0
    do_op(5'd6, 16'h0005, 16'h0002, 0, 0, 1);   // R4 5-2-1
    do_op(5'd5, 16'h0005, 16'h0005, 0, 0, 1);   // R3 equal: carry 1
    do_op(5'd7, 16'h0000, 16'h0000, 0, 0, 1);   // R4 chain read+write
    do_op(5'd3, 16'hFFFF, 16'h0000, 0, 0, 1);   // R4 chain
    do_op(5'd1, 16'hFFFF, 16'hFFFF, 0, 0, 0);   // R5 not valid: flag ignored
    do_op(5'd13, 16'h8000, 16'h000F, 0, 0, 1);  // R7 sign fill
    do_op(5'd14, 16'hA5C3, 16'h0000, 0, 0, 1);  // R8 rotate by 0
    do_op(5'd15, 16'h0001, 16'h0001, 0, 0, 1);  // R8
    do_op(5'd17, 16'hABCD, 16'h1234, 15, 8, 1); // R9 full width
    do_op(5'd17, 16'hABCD, 16'h1234, 0, 15, 1); // R9 single bit
    do_op(5'd18, 16'hFFFF, 16'h0000, 3, 12, 1); // R10 top nibble
    do_op(5'd18, 16'h00FF, 16'h1234, 15, 4, 1); // R10 mask truncated
    do_op(5'd16, 16'hF0F0, 16'hFF00, 0, 0, 1);  // R6 clear bits
    do_op(5'd25, 16'hFFFF, 16'hFFFF, 0, 0, 1);  // R11 unused
    // random stream with flag chains
    for (int i = 0; i < 4000; i++) begin
      logic [4:0] c;
      c = ($urandom % 3 == 0) ? 5'(3 + 4 * ($urandom % 2)) : 5'($urandom % 32);
      do_op(c, 16'($urandom), 16'($urandom), 4'($urandom), 4'($urandom),
            ($urandom % 5) != 0);
    end
    // reset with flag possibly set
    do_op(5'd1, 16'hFFFF, 16'h0001, 0, 0, 1);
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1 check("R1", "carry_flag after reset", carry_flag, 0);
    mflag = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_op(5'd0, 16'h0001, 16'h0002, 0, 0, 1);   // R1 flag still 0
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule